// File: doc/BRIEF.md
# Scanned Three-Bit Binary Seven-Segment Driver

This block shows the level of three input switches as three binary digits on a four-position, common-anode seven-segment display. Only one digit position is powered at a time. A free-running prescaler sets how long each position stays lit. Each lit position shows a "0" or a "1" glyph for its own switch bit. The fourth, leftmost position is never used and stays dark.

The two glyphs differ only in the outer segments A, D, E and F. Segments B and C are always lit and the middle bar G is never lit. The output stage therefore needs only the scanned switch bit to drive four segments together. The anode vector and the segment vector are registered in the same flop stage, so they change on the same clock edge.

Top module: `bitscan_display`

## Requirements
- R1: Digit position 0 (rightmost, anode bit 0) shows switch bit 0, position 1 shows bit 1 and position 2 shows bit 2, so the number reads with its most significant bit on the left.
- R2: Anode bit 3, the leftmost position, is held at 1 (dark) at all times.
- R3: Outside reset, exactly one of anode bits 2..0 is 0 (active-low enable) on every cycle.
- R4: Outside reset, segment bit 6 (G) is 1 (off), and segment bits 2 (C) and 1 (B) are 0 (on). The segment vector is ordered g,f,e,d,c,b,a from bit 6 down to bit 0 and is active low.
- R5: Segment bits 5, 4, 3 and 0 (F, E, D, A) always carry the same value. That value equals the switch bit of the enabled position, so a 1 gives glyph 1111001 and a 0 gives glyph 1000000.
- R6: Each digit position stays enabled for exactly PRESCALE clock cycles, with PRESCALE defaulting to 87,500.
- R7: The enabled position steps 0, 1, 2 and then returns to 0.
- R8: While rst_n is low at a clock edge, every anode and every segment output is 1 on the following cycle. After release, scanning starts at position 0.
- R9: A change on the switches appears on the segments of the enabled position one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_i | input | 3 | Switch levels, bit n shown on position n |
| anode_n_o | output | 4 | Digit enables, active low, bit 3 always 1 |
| seg_n_o | output | 7 | Segments g..a, active low |

## Verification
The assertions assume that the switches are synchronous to the clock and steady around the sampling edge. They also assume that rst_n is driven low from time zero, so that the registered outputs are defined before the checks start. The bench changes sw_i only on falling edges. It holds reset across several rising edges before releasing it. It runs with a small prescale value, so every one of the eight switch patterns is seen on every digit position several times.

// File: rtl/bsd_pkg.sv
// Package: shared widths and the binary glyph encoder for the scanned display.
// Assumes segment order g,f,e,d,c,b,a (bit 6..0), active low.
package bsd_pkg;
    localparam int SEG_W = 7;

    // Build the active-low glyph for one binary digit value.
    function automatic logic [SEG_W-1:0] bit_glyph(input logic b);
        // G dark, C and B lit; F, E, D, A follow the bit (lit when 0)
        return {1'b1, b, b, b, 1'b0, 1'b0, b};
    endfunction
endpackage

// File: rtl/scan_prescaler.sv
// Module: free-running prescaler that emits a one-cycle tick every TERM cycles.
// Assumes TERM >= 2. The count wraps to zero in the cycle the tick is high.
module scan_prescaler #(
    parameter int TERM = 87500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TERM > 1) ? $clog2(TERM) : 1;
    localparam logic [CW-1:0] LAST = CW'(TERM - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Count cycles and wrap at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/scan_sequencer.sv
// Module: digit scan index that steps 0..N_USED-1 on each tick and then wraps.
// Assumes N_USED >= 2.
module scan_sequencer #(
    parameter int N_USED = 3,
    parameter int IW     = (N_USED > 1) ? $clog2(N_USED) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] TOP = IW'(N_USED - 1);

    logic [IW-1:0] idx_q;
    assign idx = idx_q;

    // Advance the scan position once per prescaler tick.
    always_ff @(posedge clk) begin
        if (!rst_n)            idx_q <= '0;
        else if (tick) begin
            if (idx_q == TOP)  idx_q <= '0;
            else               idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/scan_output.sv
// Module: registers the active-low anode vector and the glyph of the scanned bit.
// Assumes idx < N_USED. Positions at or above N_USED are forced dark.
module scan_output
    import bsd_pkg::*;
#(
    parameter int N_USED = 3,
    parameter int N_DIG  = 4,
    parameter int IW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     idx,
    input  logic [N_USED-1:0] sw,
    output logic [N_DIG-1:0]  anode_n,
    output logic [SEG_W-1:0]  seg_n
);
    logic [N_DIG-1:0] anode_d;
    logic             bit_sel;

    // Per-position enable: used positions decode the index, others stay off.
    for (genvar g = 0; g < N_DIG; g++) begin : g_an
        if (g < N_USED) begin : g_used
            assign anode_d[g] = (idx != IW'(g));
        end else begin : g_blank
            assign anode_d[g] = 1'b1;
        end
    end

    // Pick the switch bit belonging to the enabled position.
    always_comb begin
        bit_sel = 1'b0;
        for (int k = 0; k < N_USED; k++)
            if (idx == IW'(k)) bit_sel = sw[k];
    end

    // Register anode and segment patterns together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            anode_n <= '1;
            seg_n   <= '1;
        end else begin
            anode_n <= anode_d;
            seg_n   <= bit_glyph(bit_sel);
        end
    end
endmodule

// File: rtl/bitscan_display.sv
// Module: top of the scanned binary display; prescaler, scan index and output stage.
// Assumes sw_i is synchronous to clk; rst_n is synchronous, active low.
module bitscan_display #(
    parameter int PRESCALE = 87500,
    parameter int N_USED   = 3,
    parameter int N_DIG    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_USED-1:0] sw_i,
    output logic [N_DIG-1:0]  anode_n_o,
    output logic [6:0]        seg_n_o
);
    localparam int IW = (N_USED > 1) ? $clog2(N_USED) : 1;

    logic          tick_w;
    logic [IW-1:0] idx_w;

    scan_prescaler #(.TERM(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick_w)
    );

    scan_sequencer #(.N_USED(N_USED), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .idx(idx_w)
    );

    scan_output #(.N_USED(N_USED), .N_DIG(N_DIG), .IW(IW)) u_out (
        .clk(clk), .rst_n(rst_n), .idx(idx_w), .sw(sw_i),
        .anode_n(anode_n_o), .seg_n(seg_n_o)
    );
endmodule

// File: rtl/bitscan_display_chk.sv
// Checker: port-level properties of the scanned display, bound to the top.
module bitscan_display_chk #(
    parameter int N_DIG = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DIG-1:0] anode_n,
    input logic [6:0]       seg_n
);
    logic run_q;

    // Mark cycles whose outputs were registered outside reset.
    always_ff @(posedge clk) run_q <= rst_n;

    AST_LEFT_DARK:   assert property (@(posedge clk) disable iff (!rst_n) run_q |-> anode_n[N_DIG-1]); // R2
    AST_ONE_ANODE:   assert property (@(posedge clk) disable iff (!rst_n) run_q |-> ($countones(~anode_n[2:0]) == 1)); // R3
    AST_FIXED_SEGS:  assert property (@(posedge clk) disable iff (!rst_n) run_q |-> (seg_n[6] && seg_n[2:1] == 2'b00)); // R4
    AST_SHARED_SEGS: assert property (@(posedge clk) disable iff (!rst_n) run_q |-> (seg_n[5] == seg_n[0] && seg_n[4] == seg_n[0] && seg_n[3] == seg_n[0])); // R5
    AST_RESET_IDLE:  assert property (@(posedge clk) (rst_n === 1'b0) |=> (&anode_n && &seg_n)); // R8
endmodule

bind bitscan_display bitscan_display_chk #(.N_DIG(N_DIG)) u_chk (
    .clk(clk), .rst_n(rst_n), .anode_n(anode_n_o), .seg_n(seg_n_o)
);

// File: tb/tb_bitscan_display.sv
`timescale 1ns/1ps
module tb_bitscan_display;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sw = 3'b000;
    logic [3:0] anode_n;
    logic [6:0] seg_n;

    int n_tests = 0;
    int n_fail  = 0;
    int prev_pos = -1;
    int run_len  = 0;

    bitscan_display #(.PRESCALE(P), .N_USED(3), .N_DIG(4)) dut (
        .clk(clk), .rst_n(rst_n), .sw_i(sw), .anode_n_o(anode_n), .seg_n_o(seg_n)
    );

    always #2 clk = ~clk;

    function automatic logic [6:0] exp_glyph(input logic b);
        return b ? 7'b1111001 : 7'b1000000;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One negedge sample: glyph, anodes and scan timing.
    task automatic sample();
        int pos;
        pos = -1;
        for (int k = 0; k < 3; k++) if (!anode_n[k]) pos = k;
        check(anode_n[3] == 1'b1, "R2", {28'b0, anode_n}, 32'h8);
        check($countones(~anode_n[2:0]) == 1, "R3", {28'b0, anode_n}, 32'h1);
        if (pos >= 0) begin
            check(seg_n == exp_glyph(sw[pos]), "R1/R4/R5/R9", {25'b0, seg_n}, {25'b0, exp_glyph(sw[pos])});
            if (pos != prev_pos) begin
                if (prev_pos >= 0) begin
                    check(pos == (prev_pos + 1) % 3, "R7", pos, (prev_pos + 1) % 3);
                    check(run_len == P, "R6", run_len, P);
                end else begin
                    check(pos == 0, "R8", pos, 0);
                end
                prev_pos = pos;
                run_len  = 1;
            end else begin
                run_len++;
            end
        end
    endtask

    initial begin
        #4000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(anode_n == 4'hF, "R8", {28'b0, anode_n}, 32'hF);
        check(seg_n == 7'h7F, "R8", {25'b0, seg_n}, 32'h7F);
        rst_n = 1'b1;
        // Sweep all switch patterns; each held for two full scans.
        for (int p = 0; p < 8; p++) begin
            sw = 3'(p);
            for (int c = 0; c < 6 * P; c++) begin
                @(negedge clk);
                sample();
            end
        end
        // Reset mid-scan returns outputs to idle and restarts at position 0.
        rst_n = 1'b0;
        @(negedge clk);
        check(anode_n == 4'hF && seg_n == 7'h7F, "R8", {21'b0, anode_n, seg_n}, 32'h7FF);
        rst_n = 1'b1;
        prev_pos = -1;
        sw = 3'b101;
        for (int c = 0; c < 3 * P; c++) begin
            @(negedge clk);
            sample();
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule